// File: doc/BRIEF.md
# Zero-Overhead Block Repeat Controller

This block lets a processor core run a short stretch of straight-line code several times without spending a branch on each pass. A repeat command supplies the address of the command itself, a block length in instruction words and a pass count. The block copies these into its own registers. From then on it watches the retiring program counter. When the last word of the block retires and another pass is due, it raises a next-PC override in that same cycle, pointing back at the first word of the block. The fetch unit can then continue from the top with no bubble.

A pass count of zero means the loop never ends by itself. A taken jump or call leaves the loop at once. While a loop runs, the interrupt controller is told to hold off entry, so a count of one can be used to guard a short sequence. Loops do not nest: a new command replaces the running loop.

In word-addressed local mode one instruction is one address step. In byte-addressed shared-memory mode each instruction takes four address steps. The block also provides the base address that a relative branch in the retiring slot should add its offset to. When that slot is the last word of a pass that wraps, the base is the already-wrapped top address, as the pipeline would see it.

Top module: `rep_loop_unit`

## Requirements
- R1: A start command with a nonzero length makes loopActive high from the next cycle. The top is startPc plus one step, and the last word is startPc plus length times one step. Length and count are captured, so later changes on startLen or startCount have no effect.
- R2: A start command with length zero is ignored, whether or not a loop is running. All state and outputs stay as they would without it.
- R3: While active, a retire of the last word on a pass that is not the final one raises wrapValid in the same cycle, with wrapPc equal to the top. Prefix words are counted as ordinary words of the block.
- R4: With a count of N (N ≥ 1), the last word retires N times. On the Nth retire wrapValid stays low, and loopActive is low from the next cycle.
- R5: A count of zero repeats the block indefinitely.
- R6: branchTaken while active clears loopActive from the next cycle and suppresses wrapValid in that cycle.
- R7: A start command while a loop runs replaces the loop with the new parameters.
- R8: irqHold is high whenever loopActive is high, and also in the cycle a nonzero-length start is accepted.
- R9: With hubMode high at start, the step is 4 address units per instruction; otherwise it is 1. The mode is captured at start and holds for the whole loop.
- R10: relBase equals the top when the last word retires on a wrapping pass, even if a branch is taken in that cycle. In all other cases it equals retirePc plus one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Repeat command strobe |
| startPc | input | PC_W | Address of the repeat command |
| startLen | input | LEN_W | Block length in instruction words |
| startCount | input | CNT_W | Pass count, 0 = forever |
| hubMode | input | 1 | 1 = byte-addressed shared-memory execution (step 4) |
| retireValid | input | 1 | An instruction retires this cycle |
| retirePc | input | PC_W | Address of the retiring instruction |
| branchTaken | input | 1 | Taken jump or call this cycle |
| wrapValid | output | 1 | Next-PC override valid |
| wrapPc | output | PC_W | Override target (loop top) |
| relBase | output | PC_W | Base address for a relative branch target |
| loopActive | output | 1 | A loop is running |
| irqHold | output | 1 | Hold off interrupt entry |

## Verification
The assertions assume that startValid and branchTaken never rise in the same cycle, since the command and a taken branch are distinct instructions. They also assume that hubMode only matters when a command is accepted. The random stimulus never drives a branch in a start cycle. It advances a modelled program counter by one step per retire, jumps it to the top on each override, and moves it to an arbitrary address on a branch. Lengths and counts are kept small, so loops end, wrap and get cancelled many times within a run.

// File: rtl/rep_loop_pkg.sv
package rep_loop_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new loop
    logic passWrap;  // last word retiring on a wrapping pass
    logic active;    // loop currently running
  } repStrobe_t;
endpackage

// File: rtl/rep_loop_ctrl.sv
module rep_loop_ctrl
  import rep_loop_pkg::*;
#(
  parameter int LEN_W = 9,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [LEN_W-1:0] startLen,
  input  logic [CNT_W-1:0] startCount,
  input  logic             retireValid,
  input  logic             branchTaken,
  input  logic             atBottom,
  output repStrobe_t       strobe,
  output logic             wrapValid,
  output logic             loopActive,
  output logic             irqHold
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             activeQ;
  logic             foreverQ;
  logic [CNT_W-1:0] remainQ;

  logic loadGo, hitBottom, finalPass, cancelGo;

  always_comb begin
    loadGo    = startValid && (startLen != '0);
    hitBottom = activeQ && retireValid && atBottom;
    finalPass = hitBottom && !foreverQ && (remainQ == CNT_ONE);
    cancelGo  = activeQ && branchTaken && !loadGo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      foreverQ <= 1'b0;
      remainQ  <= '0;
    end else if (loadGo) begin
      activeQ  <= 1'b1;
      foreverQ <= (startCount == '0);
      remainQ  <= startCount;
    end else if (cancelGo || finalPass) begin
      activeQ  <= 1'b0;
    end else if (hitBottom && !foreverQ) begin
      remainQ  <= remainQ - CNT_ONE;
    end
  end

  always_comb begin
    strobe.load     = loadGo;
    strobe.passWrap = hitBottom && !finalPass;
    strobe.active   = activeQ;
    wrapValid       = hitBottom && !finalPass && !branchTaken;
    loopActive      = activeQ;
    irqHold         = activeQ || loadGo;
  end
endmodule

// File: rtl/rep_loop_dp.sv
module rep_loop_dp
  import rep_loop_pkg::*;
#(
  parameter int PC_W     = 20,
  parameter int LEN_W    = 9,
  parameter int HUB_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  repStrobe_t       strobe,
  input  logic [PC_W-1:0]  startPc,
  input  logic [LEN_W-1:0] startLen,
  input  logic             hubMode,
  input  logic [PC_W-1:0]  retirePc,
  output logic             atBottom,
  output logic [PC_W-1:0]  wrapPc,
  output logic [PC_W-1:0]  relBase
);
  localparam int HUB_SHIFT = $clog2(HUB_STEP);
  localparam logic [PC_W-1:0] STEP_LOCAL = PC_W'(1);
  localparam logic [PC_W-1:0] STEP_HUB   = PC_W'(HUB_STEP);

  logic [PC_W-1:0] topQ, botQ;
  logic            hubQ;
  logic [PC_W-1:0] stepLive, stepUse, lenScaled, lenWide;

  always_comb begin
    stepLive  = hubMode ? STEP_HUB : STEP_LOCAL;
    lenWide   = PC_W'(startLen);
    lenScaled = hubMode ? (lenWide << HUB_SHIFT) : lenWide;
    stepUse   = strobe.active ? (hubQ ? STEP_HUB : STEP_LOCAL) : stepLive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topQ <= '0;
      botQ <= '0;
      hubQ <= 1'b0;
    end else if (strobe.load) begin
      topQ <= startPc + stepLive;
      botQ <= startPc + lenScaled;
      hubQ <= hubMode;
    end
  end

  always_comb begin
    atBottom = (retirePc == botQ);
    wrapPc   = topQ;
    relBase  = strobe.passWrap ? topQ : (retirePc + stepUse);
  end
endmodule

// File: rtl/rep_loop_unit.sv
module rep_loop_unit
  import rep_loop_pkg::*;
#(
  parameter int PC_W     = 20,
  parameter int LEN_W    = 9,
  parameter int CNT_W    = 9,
  parameter int HUB_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [PC_W-1:0]  startPc,
  input  logic [LEN_W-1:0] startLen,
  input  logic [CNT_W-1:0] startCount,
  input  logic             hubMode,
  input  logic             retireValid,
  input  logic [PC_W-1:0]  retirePc,
  input  logic             branchTaken,
  output logic             wrapValid,
  output logic [PC_W-1:0]  wrapPc,
  output logic [PC_W-1:0]  relBase,
  output logic             loopActive,
  output logic             irqHold
);
  repStrobe_t strobe;
  logic       atBottom;

  rep_loop_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startValid(startValid), .startLen(startLen), .startCount(startCount),
    .retireValid(retireValid), .branchTaken(branchTaken), .atBottom(atBottom),
    .strobe(strobe), .wrapValid(wrapValid), .loopActive(loopActive),
    .irqHold(irqHold)
  );

  rep_loop_dp #(.PC_W(PC_W), .LEN_W(LEN_W), .HUB_STEP(HUB_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .startPc(startPc), .startLen(startLen), .hubMode(hubMode),
    .retirePc(retirePc), .atBottom(atBottom), .wrapPc(wrapPc),
    .relBase(relBase)
  );
endmodule

// File: rtl/rep_loop_checker.sv
module rep_loop_checker #(
  parameter int PC_W  = 20,
  parameter int LEN_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             startValid,
  input logic [LEN_W-1:0] startLen,
  input logic             retireValid,
  input logic             branchTaken,
  input logic             wrapValid,
  input logic [PC_W-1:0]  wrapPc,
  input logic [PC_W-1:0]  relBase,
  input logic             loopActive,
  input logic             irqHold
);
  assert_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startLen != '0) |=> loopActive);
  assert_zero_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startLen == '0 && !loopActive) |=> !loopActive);
  assert_wrap_active_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrapValid |-> (loopActive && retireValid));
  assert_cancel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (loopActive && branchTaken && !startValid) |=> !loopActive);
  assert_no_wrap_branch_R6: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> !wrapValid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    loopActive |-> irqHold);
  assert_rel_top_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrapValid |-> (relBase == wrapPc));
endmodule

bind rep_loop_unit rep_loop_checker #(.PC_W(PC_W), .LEN_W(LEN_W)) u_checker (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startLen(startLen),
  .retireValid(retireValid), .branchTaken(branchTaken), .wrapValid(wrapValid),
  .wrapPc(wrapPc), .relBase(relBase), .loopActive(loopActive), .irqHold(irqHold)
);

// File: tb/rep_loop_unit_bench.sv
`timescale 1ns/1ps
module rep_loop_unit_bench;
  localparam int PC_W = 20, LEN_W = 9, CNT_W = 9;

  logic clk = 1'b0, rstN = 1'b0;
  logic startValid = 0, hubMode = 0, retireValid = 0, branchTaken = 0;
  logic [PC_W-1:0]  startPc = '0, retirePc = '0;
  logic [LEN_W-1:0] startLen = '0;
  logic [CNT_W-1:0] startCount = '0;
  logic wrapValid, loopActive, irqHold;
  logic [PC_W-1:0] wrapPc, relBase;

  rep_loop_unit u_rep_loop_unit (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startPc(startPc),
    .startLen(startLen), .startCount(startCount), .hubMode(hubMode),
    .retireValid(retireValid), .retirePc(retirePc), .branchTaken(branchTaken),
    .wrapValid(wrapValid), .wrapPc(wrapPc), .relBase(relBase),
    .loopActive(loopActive), .irqHold(irqHold)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  bit mActive = 0, mForever = 0, mHub = 0;
  logic [PC_W-1:0] mTop = '0, mBot = '0, fetchPc = 20'h100;
  int mRem = 0;
  int wrapsSeen = 0, bottomsSeen = 0;

  function automatic logic [PC_W-1:0] stepOf(input bit hub);
    return hub ? PC_W'(4) : PC_W'(1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle: drive at negedge, check, then advance the model at posedge
  task automatic cyc(input bit sv, input int len, input int cnt,
                     input bit br, input bit rv, input bit hubIn);
    bit hit, last, eWrap, lenNz;
    logic [PC_W-1:0] eRel, stepE, oldTop;
    @(negedge clk);
    startValid = sv; startLen = LEN_W'(len); startCount = CNT_W'(cnt);
    branchTaken = br; retireValid = rv; hubMode = hubIn;
    startPc = fetchPc; retirePc = fetchPc;
    #2;
    lenNz = (len != 0);
    hit   = mActive && rv && (fetchPc == mBot);
    last  = hit && !mForever && (mRem == 1);
    eWrap = hit && !last && !br;
    stepE = mActive ? stepOf(mHub) : stepOf(hubIn);
    eRel  = (hit && !last) ? mTop : fetchPc + stepE;
    chk("R1/R4/R6 loopActive", {31'd0, loopActive}, {31'd0, mActive});
    chk("R3 wrapValid", {31'd0, wrapValid}, {31'd0, eWrap});
    if (eWrap) chk("R3 wrapPc", 32'(wrapPc), 32'(mTop));
    chk("R8 irqHold", {31'd0, irqHold}, {31'd0, mActive || (sv && lenNz)});
    chk("R10 relBase", 32'(relBase), 32'(eRel));
    if (hit) bottomsSeen++;
    if (eWrap) wrapsSeen++;
    oldTop = mTop;
    @(posedge clk);
    if (sv && lenNz) begin
      mActive = 1; mHub = hubIn; mForever = (cnt == 0); mRem = cnt;
      mTop = fetchPc + stepOf(hubIn);
      mBot = fetchPc + PC_W'(len) * stepOf(hubIn);
      fetchPc = fetchPc + stepOf(hubIn);
    end else begin
      if (mActive && br) mActive = 0;
      else if (last) mActive = 0;
      else if (hit && !mForever) mRem--;
      if (eWrap) fetchPc = oldTop;
      else if (br) fetchPc = PC_W'($urandom);
      else if (rv) fetchPc = fetchPc + stepE;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    // reset state, R1 R3 R8
    chk("R1 reset loopActive", {31'd0, loopActive}, 32'd0);
    chk("R3 reset wrapValid", {31'd0, wrapValid}, 32'd0);
    chk("R8 reset irqHold", {31'd0, irqHold}, 32'd0);
    @(negedge clk); rstN = 1;

    // R2: zero length while idle is ignored
    cyc(1, 0, 3, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    // R1 + R4: length 2, count 3, operands changed afterwards (no effect)
    cyc(1, 2, 3, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 1 + i, i, 0, 1, 0);
    // R4 guard: count 1 holds interrupts for one pass (R8)
    cyc(1, 3, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0);
    // R5: count 0 repeats forever; R2 zero length ignored while active
    cyc(1, 2, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) cyc(i == 7, 0, 0, 0, 1, 0);
    // R7: restart while active; R9: hub mode captured, input flips later
    cyc(1, 3, 2, 0, 0, 1);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 1, i[0]);
    // R10: branch on last word of a wrapping pass; R6 cancel
    cyc(1, 1, 5, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);
    // R6: branch in the middle of a forever loop
    cyc(1, 4, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, i == 5, 1, 0);
    cyc(0, 0, 0, 0, 1, 0);

    // constrained random mix
    for (int n = 0; n < 20000; n++) begin
      bit sv, br, rv, hb;
      int len, cnt;
      sv  = ($urandom % 100) < (mActive ? 2 : 6);
      len = (($urandom % 10) == 0) ? 0 : 1 + ($urandom % 6);
      cnt = $urandom % 5;
      br  = !sv && (($urandom % 100) < 3);
      rv  = !sv && (($urandom % 100) < 85);
      hb  = $urandom % 2;
      cyc(sv, len, cnt, br, rv, hb);
    end
    chk("R3 random wraps occurred", {31'd0, wrapsSeen > 10}, 32'd1);
    chk("R4 random bottoms occurred", {31'd0, bottomsSeen > wrapsSeen}, 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule